// File: doc/BRIEF.md
# Two-Level Cache Inclusion Policy Controller

This block is a tag-only model of a two-level cache hierarchy that serves one requesting core. The upper level is small and the lower level is larger. Both are fully associative and keep least-recently-used order. The core presents block addresses on a valid/ready request port. The block checks the upper level first, then the lower level, and fetches from memory through a request/acknowledge port when both miss. It answers with a one-cycle response that carries a code for where the block was found.

A two-bit select input chooses how the two levels relate. Under the inclusive policy every upper-level block is also held in the lower level, so a lower-level eviction removes the same block from the upper level. Under the exclusive policy the lower level only receives blocks evicted from the upper level, so it acts as a victim store. Under the non-inclusive non-exclusive policy both levels are filled from memory, but lower-level evictions are never pushed upward. Two combinational probe ports report whether a given block is present in either level. They are used for debug and for checking.

Top module: `cache_incl_ctrl`

## Requirements
- R1: Every request looks in L1 first. On an L1 hit the response code is 2'b00, no memory request is raised, and the set of blocks held by either level does not change.
- R2: Under the inclusive (policy_sel 2'b00) and non-inclusive non-exclusive (policy_sel 2'b10, 2'b11 treated the same) policies, an L1 miss that hits in L2 answers 2'b01, installs the block in L1 and keeps it in L2. The L1 victim is dropped and L2 is unchanged.
- R3: Under the exclusive policy (policy_sel 2'b01), an L1 miss that hits in L2 answers 2'b01 and moves the block, so that afterwards it is in L1 and absent from L2.
- R4: Under the exclusive policy, a valid block evicted from L1 is written into L2. A block fetched from memory is installed in L1 only.
- R5: A miss in both levels answers 2'b10 after a memory fetch. Under the inclusive and non-inclusive non-exclusive policies the block is installed in both levels.
- R6: Under the inclusive policy, a block evicted from L2 by a fill is also removed from L1 before the response is given.
- R7: Under the non-inclusive non-exclusive policy, an L2 eviction leaves any L1 copy of that block in place.
- R8: Each level fills an invalid entry before it evicts a valid one. When it is full, it evicts the least recently installed-or-hit entry. An L1 hit does not refresh the block's age in L2.
- R9: Reset leaves both levels empty with the inclusive policy active. When policy_sel differs from the active policy while the block is idle, the block spends one cycle with req_ready low, empties both levels and adopts the new policy.
- R10: A memory fetch drives mem_req with mem_addr equal to the requested block address and holds both steady until mem_ack. req_ready stays low from acceptance until the response, so only one request is outstanding at a time.
- R11: Each accepted request produces exactly one rsp_valid pulse of one cycle. At that pulse the requested block is resident in L1.
- R12: dbg_l1_hit and dbg_l2_hit report combinationally whether the block on dbg_l1_addr or dbg_l2_addr is currently held in L1 or L2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| policy_sel | input | 2 | Inclusion policy: 00 inclusive, 01 exclusive, 10/11 non-inclusive non-exclusive |
| req_valid | input | 1 | Lookup request valid |
| req_ready | output | 1 | Controller can accept a request |
| req_addr | input | ADDR_W | Block address of the lookup |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_src | output | 2 | Hit source: 00 L1, 01 L2, 10 memory |
| mem_req | output | 1 | Memory fetch request |
| mem_addr | output | ADDR_W | Block address being fetched |
| mem_ack | input | 1 | Memory fetch completed |
| dbg_l1_addr | input | ADDR_W | Block address probed in L1 |
| dbg_l1_hit | output | 1 | Probed block is held in L1 |
| dbg_l2_addr | input | ADDR_W | Block address probed in L2 |
| dbg_l2_hit | output | 1 | Probed block is held in L2 |

## Verification
The hardest state to reach from the ports is one where the L2 replacement victim is a block that is still live in L1. Only in that state does inclusive back-invalidation differ visibly from the non-inclusive behaviour. The state arises because L1 hits leave L2 ages untouched. The stimulus therefore builds it on a 2-entry L1 and a 4-entry L2: one block is hit in L1 again after each new miss, so it stays most recent in L1 while it ages to the oldest entry in L2. The next miss then evicts it from L2. The same address sequence is run under each policy, and the outcome is read back through the response code of a repeat request and through the probe ports.

// File: rtl/cinc_pkg.sv
package cinc_pkg;

  // Inclusion policy encodings on policy_sel
  localparam logic [1:0] POL_INCL   = 2'b00;
  localparam logic [1:0] POL_EXCL   = 2'b01;
  localparam logic [1:0] POL_NONINC = 2'b10;

  // Response source codes on rsp_src
  localparam logic [1:0] SRC_L1  = 2'b00;
  localparam logic [1:0] SRC_L2  = 2'b01;
  localparam logic [1:0] SRC_MEM = 2'b10;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_LOOK  = 3'd1,
    ST_MEM   = 3'd2,
    ST_FILL2 = 3'd3,
    ST_FILL1 = 3'd4,
    ST_VICT  = 3'd5,
    ST_RESP  = 3'd6
  } seq_st_e;

endpackage

// File: rtl/cinc_tag_store.sv
// Fully associative tag array with compact LRU ages (0 = most recent).
// Valid entries always hold distinct ages 0..count-1.
module cinc_tag_store #(
  parameter int ENTRIES = 4,
  parameter int TAG_W   = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush_i,
  input  logic [TAG_W-1:0] look_tag_i,
  output logic             look_hit_o,
  input  logic             touch_i,
  input  logic             ins_i,
  input  logic [TAG_W-1:0] ins_tag_i,
  output logic             vic_valid_o,
  output logic [TAG_W-1:0] vic_tag_o,
  input  logic             inv_i,
  input  logic [TAG_W-1:0] inv_tag_i,
  input  logic [TAG_W-1:0] prb_tag_i,
  output logic             prb_hit_o
);

  localparam int AGE_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam int IDX_W = AGE_W;
  localparam logic [AGE_W-1:0] MAX_AGE = AGE_W'(ENTRIES - 1);

  logic             valid_q [ENTRIES];
  logic [TAG_W-1:0] tag_q   [ENTRIES];
  logic [AGE_W-1:0] age_q   [ENTRIES];
  logic             valid_d [ENTRIES];
  logic [TAG_W-1:0] tag_d   [ENTRIES];
  logic [AGE_W-1:0] age_d   [ENTRIES];

  logic [IDX_W-1:0] look_idx, inv_idx, free_idx, lru_idx, vic_idx;
  logic             inv_hit, free_found, upd_en;

  // Match, free-slot and LRU search
  always_comb begin
    look_hit_o = 1'b0;
    inv_hit    = 1'b0;
    prb_hit_o  = 1'b0;
    free_found = 1'b0;
    look_idx   = '0;
    inv_idx    = '0;
    free_idx   = '0;
    lru_idx    = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (valid_q[i] && tag_q[i] == look_tag_i) begin
        look_hit_o = 1'b1;
        look_idx   = IDX_W'(i);
      end
      if (valid_q[i] && tag_q[i] == inv_tag_i) begin
        inv_hit = 1'b1;
        inv_idx = IDX_W'(i);
      end
      if (valid_q[i] && tag_q[i] == prb_tag_i) prb_hit_o = 1'b1;
      if (valid_q[i] && age_q[i] == MAX_AGE) lru_idx = IDX_W'(i);
    end
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!valid_q[i]) begin
        free_found = 1'b1;
        free_idx   = IDX_W'(i);
      end
    end
    vic_idx     = free_found ? free_idx : lru_idx;
    vic_valid_o = !free_found;
    vic_tag_o   = tag_q[lru_idx];
  end

  // Next-state: flush > invalidate > install > touch
  always_comb begin
    valid_d = valid_q;
    tag_d   = tag_q;
    age_d   = age_q;
    if (flush_i) begin
      for (int i = 0; i < ENTRIES; i++) valid_d[i] = 1'b0;
    end else if (inv_i && inv_hit) begin
      valid_d[inv_idx] = 1'b0;
      for (int i = 0; i < ENTRIES; i++)
        if (valid_q[i] && age_q[i] > age_q[inv_idx]) age_d[i] = age_q[i] - 1'b1;
    end else if (ins_i) begin
      for (int i = 0; i < ENTRIES; i++)
        if (valid_q[i] && IDX_W'(i) != vic_idx && age_q[i] < MAX_AGE)
          age_d[i] = age_q[i] + 1'b1;
      valid_d[vic_idx] = 1'b1;
      tag_d[vic_idx]   = ins_tag_i;
      age_d[vic_idx]   = '0;
    end else if (touch_i && look_hit_o) begin
      for (int i = 0; i < ENTRIES; i++)
        if (valid_q[i] && age_q[i] < age_q[look_idx]) age_d[i] = age_q[i] + 1'b1;
      age_d[look_idx] = '0;
    end
  end

  assign upd_en = flush_i | inv_i | ins_i | touch_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) begin
        valid_q[i] <= 1'b0;
        tag_q[i]   <= '0;
        age_q[i]   <= '0;
      end
    end else if (upd_en) begin
      valid_q <= valid_d;
      tag_q   <= tag_d;
      age_q   <= age_d;
    end
  end

endmodule

// File: rtl/cinc_seq.sv
// Request sequencer: decides fills, moves, victim write-backs and
// back-invalidations per the active inclusion policy.
module cinc_seq
  import cinc_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        policy_sel,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              rsp_valid,
  output logic [1:0]        rsp_src,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_ack,
  output logic [ADDR_W-1:0] look_tag,
  output logic [1:0]        pol_o,
  output logic              flush,
  input  logic              l1_hit,
  input  logic              l1_vic_valid,
  input  logic [ADDR_W-1:0] l1_vic_tag,
  output logic              l1_touch,
  output logic              l1_ins,
  output logic              l1_inv,
  output logic [ADDR_W-1:0] l1_inv_tag,
  input  logic              l2_hit,
  input  logic              l2_vic_valid,
  input  logic [ADDR_W-1:0] l2_vic_tag,
  output logic              l2_touch,
  output logic              l2_ins,
  output logic [ADDR_W-1:0] l2_ins_tag,
  output logic              l2_inv
);

  seq_st_e           state_q, state_d;
  logic [ADDR_W-1:0] addr_q, addr_d, vtag_q, vtag_d;
  logic [1:0]        src_q, src_d, pol_q, pol_d;
  logic              is_incl, is_excl;

  assign is_incl = (pol_q == POL_INCL);
  assign is_excl = (pol_q == POL_EXCL);

  always_comb begin
    state_d    = state_q;
    addr_d     = addr_q;
    vtag_d     = vtag_q;
    src_d      = src_q;
    pol_d      = pol_q;
    flush      = 1'b0;
    l1_touch   = 1'b0;
    l1_ins     = 1'b0;
    l1_inv     = 1'b0;
    l1_inv_tag = l2_vic_tag;
    l2_touch   = 1'b0;
    l2_ins     = 1'b0;
    l2_ins_tag = addr_q;
    l2_inv     = 1'b0;
    mem_req    = 1'b0;
    rsp_valid  = 1'b0;
    req_ready  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (policy_sel != pol_q) begin
          flush = 1'b1;
          pol_d = policy_sel;
        end else begin
          req_ready = 1'b1;
          if (req_valid) begin
            addr_d  = req_addr;
            state_d = ST_LOOK;
          end
        end
      end
      ST_LOOK: begin
        if (l1_hit) begin
          l1_touch = 1'b1;
          src_d    = SRC_L1;
          state_d  = ST_RESP;
        end else if (l2_hit) begin
          src_d    = SRC_L2;
          l2_inv   = is_excl;
          l2_touch = !is_excl;
          state_d  = ST_FILL1;
        end else begin
          src_d    = SRC_MEM;
          state_d  = ST_MEM;
        end
      end
      ST_MEM: begin
        mem_req = 1'b1;
        if (mem_ack) state_d = is_excl ? ST_FILL1 : ST_FILL2;
      end
      ST_FILL2: begin
        l2_ins  = 1'b1;
        l1_inv  = is_incl && l2_vic_valid;
        state_d = ST_FILL1;
      end
      ST_FILL1: begin
        l1_ins = 1'b1;
        if (is_excl && l1_vic_valid) begin
          vtag_d  = l1_vic_tag;
          state_d = ST_VICT;
        end else begin
          state_d = ST_RESP;
        end
      end
      ST_VICT: begin
        l2_ins     = 1'b1;
        l2_ins_tag = vtag_q;
        state_d    = ST_RESP;
      end
      ST_RESP: begin
        rsp_valid = 1'b1;
        state_d   = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      vtag_q  <= '0;
      src_q   <= SRC_L1;
      pol_q   <= POL_INCL;
    end else begin
      state_q <= state_d;
      addr_q  <= addr_d;
      vtag_q  <= vtag_d;
      src_q   <= src_d;
      pol_q   <= pol_d;
    end
  end

  assign rsp_src  = src_q;
  assign mem_addr = addr_q;
  assign look_tag = addr_q;
  assign pol_o    = pol_q;

endmodule

// File: rtl/cache_incl_ctrl.sv
module cache_incl_ctrl #(
  parameter int ADDR_W     = 16,
  parameter int L1_ENTRIES = 4,
  parameter int L2_ENTRIES = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        policy_sel,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              rsp_valid,
  output logic [1:0]        rsp_src,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_ack,
  input  logic [ADDR_W-1:0] dbg_l1_addr,
  output logic              dbg_l1_hit,
  input  logic [ADDR_W-1:0] dbg_l2_addr,
  output logic              dbg_l2_hit
);

  logic [ADDR_W-1:0] look_tag, l1_vic_tag, l2_vic_tag, l1_inv_tag, l2_ins_tag;
  logic [1:0]        pol_q;
  logic flush, l1_hit, l2_hit, l1_vic_valid, l2_vic_valid;
  logic l1_touch, l1_ins, l1_inv, l2_touch, l2_ins, l2_inv;

  cinc_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .policy_sel(policy_sel),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .rsp_valid(rsp_valid), .rsp_src(rsp_src),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack),
    .look_tag(look_tag), .pol_o(pol_q), .flush(flush),
    .l1_hit(l1_hit), .l1_vic_valid(l1_vic_valid), .l1_vic_tag(l1_vic_tag),
    .l1_touch(l1_touch), .l1_ins(l1_ins), .l1_inv(l1_inv), .l1_inv_tag(l1_inv_tag),
    .l2_hit(l2_hit), .l2_vic_valid(l2_vic_valid), .l2_vic_tag(l2_vic_tag),
    .l2_touch(l2_touch), .l2_ins(l2_ins), .l2_ins_tag(l2_ins_tag), .l2_inv(l2_inv)
  );

  cinc_tag_store #(.ENTRIES(L1_ENTRIES), .TAG_W(ADDR_W)) u_l1 (
    .clk(clk), .rst_n(rst_n), .flush_i(flush),
    .look_tag_i(look_tag), .look_hit_o(l1_hit), .touch_i(l1_touch),
    .ins_i(l1_ins), .ins_tag_i(look_tag),
    .vic_valid_o(l1_vic_valid), .vic_tag_o(l1_vic_tag),
    .inv_i(l1_inv), .inv_tag_i(l1_inv_tag),
    .prb_tag_i(dbg_l1_addr), .prb_hit_o(dbg_l1_hit)
  );

  cinc_tag_store #(.ENTRIES(L2_ENTRIES), .TAG_W(ADDR_W)) u_l2 (
    .clk(clk), .rst_n(rst_n), .flush_i(flush),
    .look_tag_i(look_tag), .look_hit_o(l2_hit), .touch_i(l2_touch),
    .ins_i(l2_ins), .ins_tag_i(l2_ins_tag),
    .vic_valid_o(l2_vic_valid), .vic_tag_o(l2_vic_tag),
    .inv_i(l2_inv), .inv_tag_i(look_tag),
    .prb_tag_i(dbg_l2_addr), .prb_hit_o(dbg_l2_hit)
  );

endmodule

// File: rtl/cinc_chk.sv
module cinc_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic [1:0]        rsp_src,
  input logic              mem_req,
  input logic              mem_ack,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [1:0]        pol_q,
  input logic              l1_hit,
  input logic              l2_hit
);

  AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid); // R11

  AST_RSP_IN_L1: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> l1_hit); // R11

  AST_SRC_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> rsp_src != 2'b11); // R5

  AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready); // R10

  AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr))); // R10

  AST_BUSY_DURING_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !req_ready); // R10

  AST_INCL_SUBSET: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && pol_q == 2'b00) |-> l2_hit); // R6

  AST_EXCL_DISJOINT: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && pol_q == 2'b01) |-> !l2_hit); // R3

endmodule

bind cache_incl_ctrl cinc_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .rsp_valid(rsp_valid), .rsp_src(rsp_src), .mem_req(mem_req),
  .mem_ack(mem_ack), .mem_addr(mem_addr), .pol_q(pol_q),
  .l1_hit(l1_hit), .l2_hit(l2_hit)
);

// File: tb/cache_incl_ctrl_bench.sv
module cache_incl_ctrl_bench;

  localparam int AW = 8;
  localparam logic [1:0] PI = 2'b00, PE = 2'b01, PN = 2'b10;
  localparam logic [1:0] S1 = 2'b00, S2 = 2'b01, SM = 2'b10;
  localparam int NV = 34;

  // {policy, block address, expected source}
  localparam logic [11:0] VEC [NV] = '{
    // inclusive: fills, L1 hits, back-invalidation of block 1 (R6, R8)
    {PI,8'd1,SM}, {PI,8'd2,SM}, {PI,8'd1,S1}, {PI,8'd3,SM}, {PI,8'd1,S1},
    {PI,8'd4,SM}, {PI,8'd1,S1}, {PI,8'd5,SM}, {PI,8'd1,SM}, {PI,8'd3,S2},
    {PI,8'd3,S1}, {PI,8'd4,S2},
    // non-inclusive non-exclusive: block 1 survives in L1 (R7)
    {PN,8'd1,SM}, {PN,8'd2,SM}, {PN,8'd1,S1}, {PN,8'd3,SM}, {PN,8'd1,S1},
    {PN,8'd4,SM}, {PN,8'd1,S1}, {PN,8'd5,SM}, {PN,8'd1,S1}, {PN,8'd2,S2},
    {PN,8'd2,S1},
    // exclusive: victims fill L2, L2 hits move up (R3, R4)
    {PE,8'd1,SM}, {PE,8'd2,SM}, {PE,8'd3,SM}, {PE,8'd1,S2}, {PE,8'd1,S1},
    {PE,8'd2,S2}, {PE,8'd3,S2}, {PE,8'd3,S1}, {PE,8'd2,S1}, {PE,8'd1,S2},
    // back to inclusive: flush makes block 1 a miss (R9)
    {PI,8'd1,SM}
  };

  localparam logic [7:0] SEQ [8] = '{8'd1, 8'd2, 8'd1, 8'd3, 8'd1, 8'd4, 8'd1, 8'd5};

  logic          clk, rst_n, req_valid, req_ready, rsp_valid, mem_req, mem_ack;
  logic [1:0]    policy_sel, rsp_src;
  logic [AW-1:0] req_addr, mem_addr, dbg_l1_addr, dbg_l2_addr;
  logic          dbg_l1_hit, dbg_l2_hit;

  int n_vec, n_bad, ack_cnt, cycles;
  logic [AW-1:0] cur_addr;
  logic          mem_seen;
  logic [1:0]    got;

  cache_incl_ctrl #(.ADDR_W(AW), .L1_ENTRIES(2), .L2_ENTRIES(4)) u_cache_incl_ctrl (
    .clk(clk), .rst_n(rst_n), .policy_sel(policy_sel),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .rsp_valid(rsp_valid), .rsp_src(rsp_src),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack),
    .dbg_l1_addr(dbg_l1_addr), .dbg_l1_hit(dbg_l1_hit),
    .dbg_l2_addr(dbg_l2_addr), .dbg_l2_hit(dbg_l2_hit)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  // Memory model: acknowledge after a short delay, check the held request
  always @(negedge clk) begin
    if (rst_n) begin
      if (mem_ack) begin
        mem_ack = 1'b0;
      end else if (mem_req) begin
        mem_seen = 1'b1;
        chk("R10 ready low during fetch", {31'd0, req_ready}, 32'd0);
        chk("R10 mem_addr", {24'd0, mem_addr}, {24'd0, cur_addr});
        if (ack_cnt == 2) begin
          mem_ack = 1'b1;
          ack_cnt = 0;
        end else begin
          ack_cnt++;
        end
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      n_vec++;
      n_bad++;
      $display("FAIL R10 watchdog actual=hung expected=response");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  // Issue one lookup; returns at a falling edge after the response
  task automatic do_req(input logic [1:0] pol, input logic [AW-1:0] a,
                        output logic [1:0] src);
    policy_sel = pol;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    mem_seen  = 1'b0;
    cur_addr  = a;
    req_addr  = a;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    while (!rsp_valid) @(negedge clk);
    src = rsp_src;
    dbg_l1_addr = a;
    #1;
    chk("R11 block in L1 at response", {31'd0, dbg_l1_hit}, 32'd1);
    @(negedge clk);
    chk("R11 single pulse", {31'd0, rsp_valid}, 32'd0);
  endtask

  task automatic probe(input string rq, input logic [AW-1:0] a,
                       input logic e1, input logic e2);
    dbg_l1_addr = a;
    dbg_l2_addr = a;
    #1;
    chk({rq, " L1 probe"}, {31'd0, dbg_l1_hit}, {31'd0, e1});
    chk({rq, " L2 probe"}, {31'd0, dbg_l2_hit}, {31'd0, e2});
  endtask

  function automatic string src_req(input logic [1:0] pol, input logic [1:0] s);
    if (s == S1) return "R1";
    if (s == SM) return "R5";
    return (pol == PE) ? "R3" : "R2";
  endfunction

  initial begin
    n_vec = 0; n_bad = 0; ack_cnt = 0; cycles = 0;
    rst_n = 1'b0; req_valid = 1'b0; mem_ack = 1'b0; mem_seen = 1'b0;
    policy_sel = PI; req_addr = '0; cur_addr = '0;
    dbg_l1_addr = 8'd1; dbg_l2_addr = 8'd1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R9: reset state
    chk("R9 reset ready", {31'd0, req_ready}, 32'd1);
    chk("R9 reset rsp_valid", {31'd0, rsp_valid}, 32'd0);
    chk("R9 reset mem_req", {31'd0, mem_req}, 32'd0);
    probe("R12 reset empty", 8'd1, 1'b0, 1'b0);

    // Table walk
    for (int i = 0; i < NV; i++) begin
      logic [1:0] p, e;
      logic [7:0] a;
      p = VEC[i][11:10];
      a = VEC[i][9:2];
      e = VEC[i][1:0];
      do_req(p, a, got);
      chk(src_req(p, e), {30'd0, got}, {30'd0, e});
      if (e == S1) chk("R1 no memory fetch on L1 hit", {31'd0, mem_seen}, 32'd0);
      else if (e == SM) chk("R5 memory fetch on miss", {31'd0, mem_seen}, 32'd1);
    end

    // R9: after switching back, only block 1 is held; 3 was flushed
    probe("R9 flushed", 8'd3, 1'b0, 1'b0);
    probe("R5 both levels after fill", 8'd1, 1'b1, 1'b1);

    // R4 / R3: exclusive victim store
    do_req(PE, 8'd9, got);
    chk("R4 fetch", {30'd0, got}, {30'd0, SM});
    probe("R4 memory fill to L1 only", 8'd9, 1'b1, 1'b0);
    do_req(PE, 8'd10, got);
    do_req(PE, 8'd11, got);
    probe("R4 victim written to L2", 8'd9, 1'b0, 1'b1);
    do_req(PE, 8'd9, got);
    chk("R3 L2 hit", {30'd0, got}, {30'd0, S2});
    probe("R3 moved out of L2", 8'd9, 1'b1, 1'b0);
    probe("R4 new victim in L2", 8'd10, 1'b0, 1'b1);

    // R7: block 1 stays in L1 after its L2 eviction
    for (int k = 0; k < 8; k++) do_req(PN, SEQ[k], got);
    probe("R7 L1 copy kept", 8'd1, 1'b1, 1'b0);

    // R6 / R8: same sequence evicts block 1 from both levels
    for (int k = 0; k < 8; k++) do_req(PI, SEQ[k], got);
    probe("R6 back-invalidated", 8'd1, 1'b0, 1'b0);
    probe("R8 invalid slot reused", 8'd4, 1'b1, 1'b1);
    probe("R8 newest in both", 8'd5, 1'b1, 1'b1);
    probe("R8 L2 holds older", 8'd2, 1'b0, 1'b1);

    // R2: L2 hit under inclusive keeps the L2 copy
    do_req(PI, 8'd2, got);
    chk("R2 L2 hit", {30'd0, got}, {30'd0, S2});
    probe("R2 kept in L2", 8'd2, 1'b1, 1'b1);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule